// File: doc/BRIEF.md
# Incrementing-Pattern Beat Checker

This block watches a 128-bit beat stream and compares it, word by word, against a deterministic test pattern. Each 64-bit word of the pattern is a fixed 32-bit tag (`0xCAFEBABE`) in its upper half and a 32-bit running sequence value in its lower half. Every beat carries two consecutive words. The block finds stream faults such as words that repeat data from an earlier burst, or words that arrive as all zeros after a loopback through memory.

The checker is a passive tap. It is always ready and never stalls the stream. Software or a sequencer loads the sequence start value before each transfer block, so every block can be checked on its own. The block keeps a sticky error flag and a saturating count of bad words. It also captures the position and the received value of the first bad word, so the fault can be placed within the transfer. A clear input resets this log.

Top module: `pchk_top`

## Requirements
- R1: The expected word with sequence value v is {0xCAFEBABE, v}. In a beat checked at sequence value n, data[63:0] must equal the word for n and data[127:64] the word for n+1. After reset, n is 0.
- R2: A cycle with load_i high sets the sequence value to start_i and the word index to 0. A beat presented in that same cycle is not checked and does not advance the sequence.
- R3: Every accepted beat (valid high, load low) advances the sequence value by 2, modulo 2^32, and the word index by 2, whether or not it mismatched.
- R4: Every mismatching word adds one to err_count_o, so a beat adds 0, 1 or 2. An all-zero word and a word repeating an earlier sequence value both count as mismatches.
- R5: err_count_o saturates at 2^CNT_W-1 and never wraps.
- R6: err_flag_o rises with the first mismatch and stays high until clear_i.
- R7: first_idx_o and first_word_o hold the word index and the received 64-bit value of the first mismatching word since reset or clear. The lower word wins when both words of a beat fail. Later mismatches leave both outputs unchanged.
- R8: clear_i zeroes err_flag_o, err_count_o, first_idx_o and first_word_o. Mismatches of a beat in the same cycle are dropped, but that beat still advances the sequence.
- R9: beat_ready_o is always high. The last marker does not restart the pattern, so the sequence carries on across burst boundaries.
- R10: The error outputs reflect an accepted beat from the first rising edge after that beat. All outputs are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear_i | input | 1 | Clears the error log |
| load_i | input | 1 | Loads the sequence start value |
| start_i | input | 32 | Sequence start value |
| beat_valid_i | input | 1 | Beat present |
| beat_data_i | input | 128 | Beat data, two 64-bit words |
| beat_last_i | input | 1 | Last beat of a burst |
| beat_ready_o | output | 1 | Always high |
| err_flag_o | output | 1 | Sticky mismatch flag |
| err_count_o | output | CNT_W | Saturating count of bad words |
| first_idx_o | output | IDX_W | Word index of the first bad word |
| first_word_o | output | 64 | Received value of the first bad word |

## Verification
On every cycle the assertions check the local rules. Each accepted beat steps the sequence by two, the last marker included. Ready never drops. The count never falls without a clear, never rises by more than two per beat, and holds at saturation. The flag and the capture hold once set. Only the bench scenarios can show that the values themselves are right. That means the tag and lane order, the load point, wrap of the sequence at 2^32, lane priority for the capture, and the clear-versus-beat collision. The bench checks these against its own model of the pattern.

// File: rtl/pchk_pkg.sv
package pchk_pkg;

    localparam int HALF_W = 32;
    localparam int WORD_W = 2 * HALF_W;
    localparam int LANES  = 2;
    localparam int BEAT_W = LANES * WORD_W;
    localparam logic [HALF_W-1:0] PAT_TAG = 32'hCAFE_BABE;

    typedef logic [HALF_W-1:0] seq_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic  bad;
        word_t got;
    } lane_res_t;

    function automatic word_t pat_word(seq_t v);
        return {PAT_TAG, v};
    endfunction

endpackage

// File: rtl/pchk_seq_gen.sv
module pchk_seq_gen
    import pchk_pkg::*;
#(
    parameter int IDX_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  seq_t             start_i,
    input  logic             advance_i,
    input  logic             last_i,
    output seq_t             seq_o,
    output logic [IDX_W-1:0] idx_o
);

    localparam seq_t             SEQ_STEP = seq_t'(LANES);
    localparam logic [IDX_W-1:0] IDX_STEP = IDX_W'(LANES);

    seq_t             seq_q;
    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q <= '0;
            idx_q <= '0;
        end else if (load_i) begin
            seq_q <= start_i;
            idx_q <= '0;
        end else if (advance_i) begin
            seq_q <= seq_q + SEQ_STEP;
            idx_q <= idx_q + IDX_STEP;
        end
    end

    assign seq_o = seq_q;
    assign idx_o = idx_q;

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
        (advance_i && !load_i) |=> (seq_q == $past(seq_q) + SEQ_STEP)); // R3
    AST_LAST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        (advance_i && last_i && !load_i) |=> (idx_q == $past(idx_q) + IDX_STEP)); // R9
    AST_LOAD_POINT: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (seq_q == $past(start_i) && idx_q == '0)); // R2

endmodule

// File: rtl/pchk_lane_cmp.sv
module pchk_lane_cmp
    import pchk_pkg::*;
(
    input  logic [BEAT_W-1:0]           beat_i,
    input  seq_t                        seq_i,
    output lane_res_t [LANES-1:0]       res_o
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        word_t got_w;
        word_t exp_w;
        assign got_w          = beat_i[l*WORD_W +: WORD_W];
        assign exp_w          = pat_word(seq_i + seq_t'(l));
        assign res_o[l].got   = got_w;
        assign res_o[l].bad   = (got_w != exp_w);
    end

endmodule

// File: rtl/pchk_err_log.sv
module pchk_err_log
    import pchk_pkg::*;
#(
    parameter int IDX_W = 32,
    parameter int CNT_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clear_i,
    input  logic                  record_i,
    input  lane_res_t [LANES-1:0] res_i,
    input  logic [IDX_W-1:0]      idx_i,
    output logic                  flag_o,
    output logic [CNT_W-1:0]      count_o,
    output logic [IDX_W-1:0]      first_idx_o,
    output word_t                 first_word_o
);

    localparam int               SUM_W   = CNT_W + 2;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [SUM_W-1:0]  n_bad;
    logic [SUM_W-1:0]  sum_w;
    logic [CNT_W-1:0]  count_nx;
    logic              any_bad;
    logic [IDX_W-1:0]  pick_idx;
    word_t             pick_word;

    logic              flag_q;
    logic [CNT_W-1:0]  count_q;
    logic [IDX_W-1:0]  fidx_q;
    word_t             fword_q;

    always_comb begin
        n_bad     = '0;
        any_bad   = 1'b0;
        pick_idx  = '0;
        pick_word = '0;
        for (int l = LANES - 1; l >= 0; l--) begin
            if (res_i[l].bad) begin
                n_bad     = n_bad + SUM_W'(1);
                any_bad   = 1'b1;
                pick_idx  = idx_i + IDX_W'(l);
                pick_word = res_i[l].got;
            end
        end
        sum_w    = SUM_W'(count_q) + n_bad;
        count_nx = (sum_w > SUM_W'(CNT_MAX)) ? CNT_MAX : sum_w[CNT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            flag_q  <= 1'b0;
            count_q <= '0;
            fidx_q  <= '0;
            fword_q <= '0;
        end else if (record_i && any_bad) begin
            flag_q  <= 1'b1;
            count_q <= count_nx;
            if (!flag_q) begin
                fidx_q  <= pick_idx;
                fword_q <= pick_word;
            end
        end
    end

    assign flag_o       = flag_q;
    assign count_o      = count_q;
    assign first_idx_o  = fidx_q;
    assign first_word_o = fword_q;

    AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        !clear_i |=> (count_q >= $past(count_q))); // R5
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        !clear_i |=> (SUM_W'(count_q) <= SUM_W'($past(count_q)) + SUM_W'(LANES))); // R4
    AST_CNT_HOLD_MAX: assert property (@(posedge clk) disable iff (rst)
        (count_q == CNT_MAX && !clear_i) |=> (count_q == CNT_MAX)); // R5
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !clear_i) |=> flag_q); // R6
    AST_FIRST_HELD: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !clear_i) |=> ($stable(fidx_q) && $stable(fword_q))); // R7
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> (!flag_q && count_q == '0 && fidx_q == '0)); // R8

endmodule

// File: rtl/pchk_top.sv
module pchk_top
    import pchk_pkg::*;
#(
    parameter int IDX_W = 32,
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear_i,
    input  logic              load_i,
    input  logic [31:0]       start_i,
    input  logic              beat_valid_i,
    input  logic [127:0]      beat_data_i,
    input  logic              beat_last_i,
    output logic              beat_ready_o,
    output logic              err_flag_o,
    output logic [CNT_W-1:0]  err_count_o,
    output logic [IDX_W-1:0]  first_idx_o,
    output logic [63:0]       first_word_o
);

    seq_t                  seq_w;
    logic [IDX_W-1:0]      idx_w;
    lane_res_t [LANES-1:0] res_w;
    logic                  accept_w;

    assign beat_ready_o = 1'b1;
    assign accept_w     = beat_valid_i && !load_i;

    pchk_seq_gen #(.IDX_W(IDX_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .load_i    (load_i),
        .start_i   (start_i),
        .advance_i (beat_valid_i),
        .last_i    (beat_last_i),
        .seq_o     (seq_w),
        .idx_o     (idx_w)
    );

    pchk_lane_cmp u_cmp (
        .beat_i (beat_data_i),
        .seq_i  (seq_w),
        .res_o  (res_w)
    );

    pchk_err_log #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_log (
        .clk          (clk),
        .rst          (rst),
        .clear_i      (clear_i),
        .record_i     (accept_w),
        .res_i        (res_w),
        .idx_i        (idx_w),
        .flag_o       (err_flag_o),
        .count_o      (err_count_o),
        .first_idx_o  (first_idx_o),
        .first_word_o (first_word_o)
    );

    AST_READY_HIGH: assert property (@(posedge clk) disable iff (rst)
        beat_ready_o); // R9
    AST_FLAG_VS_COUNT: assert property (@(posedge clk) disable iff (rst)
        (err_flag_o == (err_count_o != '0))); // R6

endmodule

// File: tb/pchk_top_tb.sv
module pchk_top_tb;

    localparam int CLK_PERIOD = 10;
    localparam int IDX_W = 32;
    localparam int CNT_W = 8;
    localparam logic [31:0] TAG = 32'hCAFEBABE;

    logic              clk = 1'b0;
    logic              rst;
    logic              clear_i;
    logic              load_i;
    logic [31:0]       start_i;
    logic              beat_valid_i;
    logic [127:0]      beat_data_i;
    logic              beat_last_i;
    logic              beat_ready_o;
    logic              err_flag_o;
    logic [CNT_W-1:0]  err_count_o;
    logic [IDX_W-1:0]  first_idx_o;
    logic [63:0]       first_word_o;

    pchk_top #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        string            req;
        logic             flag;
        logic [CNT_W-1:0] cnt;
        logic [IDX_W-1:0] fidx;
        logic [63:0]      fword;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int failures = 0;
    bit done = 0;

    // bench model of the pattern and log
    logic [31:0]      m_seq;
    logic [IDX_W-1:0] m_idx;
    logic             m_flag;
    logic [CNT_W-1:0] m_cnt;
    logic [IDX_W-1:0] m_fidx;
    logic [63:0]      m_fword;

    function automatic logic [127:0] good_beat(logic [31:0] n);
        return {TAG, n + 32'd1, TAG, n};
    endfunction

    task automatic check1(string req, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_seq = 0; m_idx = 0; m_flag = 0; m_cnt = 0; m_fidx = 0; m_fword = 0;
    endtask

    // driver: one cycle of stimulus, pushes the expected log state
    task automatic step(string req, logic v, logic [127:0] d, logic lst,
                        logic clr, logic ld, logic [31:0] sv);
        exp_t e;
        @(negedge clk);
        beat_valid_i = v; beat_data_i = d; beat_last_i = lst;
        clear_i = clr; load_i = ld; start_i = sv;
        @(posedge clk);
        if (v && !ld && !clr) begin
            for (int l = 0; l < 2; l++) begin
                logic [63:0] w;
                w = d[l*64 +: 64];
                if (w !== {TAG, m_seq + 32'(l)}) begin
                    if (!m_flag) begin
                        m_fidx  = m_idx + IDX_W'(l);
                        m_fword = w;
                    end
                    m_flag = 1;
                    if (m_cnt != '1) m_cnt = m_cnt + 1'b1;
                end
            end
        end
        if (clr) begin
            m_flag = 0; m_cnt = 0; m_fidx = 0; m_fword = 0;
        end
        if (ld) begin
            m_seq = sv; m_idx = 0;
        end else if (v) begin
            m_seq = m_seq + 32'd2; m_idx = m_idx + IDX_W'(2);
        end
        e.req = req; e.flag = m_flag; e.cnt = m_cnt; e.fidx = m_fidx; e.fword = m_fword;
        exp_q.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        beat_valid_i = 0; clear_i = 0; load_i = 0; beat_last_i = 0;
    endtask

    // monitor: compares after each edge that carried stimulus
    always @(negedge clk) begin
        while (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (err_flag_o !== e.flag || err_count_o !== e.cnt ||
                first_idx_o !== e.fidx || first_word_o !== e.fword) begin
                failures++;
                $display("FAIL %s actual flag=%0b cnt=%0d idx=%0d word=%h expected flag=%0b cnt=%0d idx=%0d word=%h",
                         e.req, err_flag_o, err_count_o, first_idx_o, first_word_o,
                         e.flag, e.cnt, e.fidx, e.fword);
            end
            if (beat_ready_o !== 1'b1) begin
                failures++;
                $display("FAIL R9 actual ready=%0b expected ready=1", beat_ready_o);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1; clear_i = 0; load_i = 0; start_i = 0;
        beat_valid_i = 0; beat_data_i = 0; beat_last_i = 0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        // R10: reset state
        check1("R10 reset", {err_flag_o, err_count_o, first_idx_o, first_word_o}, '0);
        check1("R9 ready", 128'(beat_ready_o), 128'd1);

        // R1/R3: clean stream from zero, last marker on beat 3
        for (int i = 0; i < 4; i++)
            step("R1 clean", 1, good_beat(32'(2*i)), i == 3, 0, 0, 0);
        // R9: pattern continues across the burst boundary
        step("R9 after last", 1, good_beat(32'd8), 0, 0, 0, 0);
        idle();
        step("R3 gap", 1, good_beat(32'd10), 1, 0, 0, 0);
        // R4/R6/R7: all-zero beat, both lanes bad, lower lane captured
        step("R4 zero beat", 1, '0, 0, 0, 0, 0);
        // R3: counter advanced despite mismatch; flag held
        step("R6 good after bad", 1, good_beat(32'd14), 0, 0, 0, 0);
        // R4/R7: stale upper word; capture unchanged
        step("R7 later bad", 1, {TAG, 32'd3, TAG, 32'd16}, 0, 0, 0, 0);
        idle();
        // R8: clear
        step("R8 clear", 0, '0, 0, 1, 0, 0);
        // R7: only upper lane bad -> index is base+1
        step("R7 upper lane", 1, {TAG, 32'd5, TAG, 32'd18}, 0, 0, 0, 0);
        step("R8 clear2", 0, '0, 0, 1, 0, 0);
        // R8: clear with a bad beat in same cycle drops it, sequence still moves
        step("R8 clear+beat", 1, '0, 0, 1, 0, 0);
        step("R8 seq moved", 1, good_beat(32'd22), 0, 0, 0, 0);
        // R2: load with a bad beat in same cycle; beat ignored
        step("R2 load", 1, '0, 0, 0, 1, 32'hFFFF_FFFE);
        // R2/R3: start value honoured and wrap at 2^32
        step("R2 start", 1, good_beat(32'hFFFF_FFFE), 0, 0, 0, 0);
        step("R3 wrap", 1, good_beat(32'd0), 0, 0, 0, 0);
        // R4: stale repeat of earlier block in lower lane, index from load point
        step("R4 stale", 1, {TAG, 32'd3, TAG, 32'd1}, 0, 0, 0, 0);
        idle();
        // R5: saturation
        for (int i = 0; i < 130; i++)
            step("R5 saturate", 1, '0, 0, 0, 0, 0);
        step("R5 hold max", 1, '0, 1, 0, 0, 0);
        idle();
        check1("R5 count max", 128'(err_count_o), 128'd255);
        check1("R9 ready end", 128'(beat_ready_o), 128'd1);
        idle();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule